// File: doc/BRIEF.md
# PPS Exchange Tracker

This block watches the character stream of a smart-card session as a passive observer. It decodes the answer-to-reset structure, the protocol-and-parameter-selection (PPS) request and the PPS response in real time. It exists so that the character receiver beside it can switch its half-etu count on the exact character that ends the PPS response, with no software in the loop. Without this, the first fast command after the exchange would be lost.

A session-start pulse comes from the rising edge of the card reset line. Characters arrive as an 8-bit value with a one-cycle valid strobe, in the order they were seen on the wire, and they are not inverted. The block drives a load strobe and a new half-etu value to the receiver. It also raises an action flag on the same cycle, so the character being forwarded can be marked. After one exchange, or at the first byte that breaks the expected structure, the block goes idle until the next session start. Only direct-convention answers are followed. Parity and check bytes are not verified.

Top module: `pps_tracker`

## Requirements
- R1: After `rst_n` is released, the block is idle. No character stream, not even a complete valid exchange, produces `etu_load` until `sess_start` has pulsed.
- R2: `sess_start` restarts parsing at the first answer byte from any state. If `chr_valid` is high in the same cycle, that character is ignored.
- R3: If the first character of a session is not 8'h3B, the block goes idle for the rest of the session.
- R4: The answer length follows the format byte and each interface-indicator byte. Bits 7..4 of each declare which of up to four interface bytes follow, and the fourth of these is the next indicator. Bits 3..0 of the format byte give the count of historical bytes. A final check byte is expected only if some indicator has a nonzero protocol field in bits 3..0.
- R5: The character after the answer must be 8'hFF, or the block goes idle for the session.
- R6: In the request, bits 4, 5 and 6 of the format byte each add one optional byte before the request check byte.
- R7: The response must begin with 8'hFF. Its format byte may set a bit among 6..4 only if the request set that bit. Any violation makes the block idle.
- R8: On the strobe of the response check byte after a valid exchange that echoes the first parameter byte (bits 7..4 rate index F, bits 3..0 divider index D), `etu_load` and `pps_act` are high in that same cycle, and `etu_value` equals (F/D)/2.
- R9: If the rate index or the divider index is reserved, or if (F/D)/2 is not a whole number, is zero, or does not fit in `HALF_W` bits, no load is given.
- R10: After the response check byte, the block stays idle. A repeated exchange in the same session gives no load, and a new session works again.
- R11: A response whose format byte does not echo the first parameter byte (bit 4 clear) ends the exchange without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_start | input | 1 | One-cycle pulse at the start of a card session |
| chr_valid | input | 1 | One-cycle strobe: a received character is on chr_data |
| chr_data | input | 8 | Received character, bits as seen on the wire |
| etu_load | output | 1 | Reload the receiver's half-etu count now |
| etu_value | output | HALF_W | New half-etu count, valid while etu_load is high |
| pps_act | output | 1 | Marks the current character as the one that caused the reload |

## Verification
The assertions assume that `chr_valid` only pulses for whole characters and never while the receiver is still mid-character. They also assume that `sess_start` is a single-cycle pulse that may coincide with a character strobe. The bench keeps to this by driving each strobe for exactly one clock, with idle cycles in between. It raises the start pulse on its own, except in the one scenario that overlaps it with a strobe on purpose. Exchanges are built by hand so that every early exit from the answer, request and response is reached. Load timing is sampled while the final strobe is still high.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    ST_OFF,     // idle until next session
    ST_TS,      // waiting for initial character
    ST_T0,      // format byte of the answer
    ST_IFC,     // interface bytes of one group
    ST_HIST,    // historical bytes
    ST_TCK,     // answer check byte
    ST_RQ_SS,   // request start byte
    ST_RQ_P0,   // request format byte
    ST_RQ_OPT,  // request optional bytes
    ST_RQ_CK,   // request check byte
    ST_RS_SS,   // response start byte
    ST_RS_P0,   // response format byte
    ST_RS_P1,   // response first parameter byte
    ST_RS_OPT,  // response remaining optional bytes
    ST_RS_CK    // response check byte
  } trk_state_e;

  // Clock rate conversion factor from its index; zero marks a reserved code.
  function automatic logic [11:0] rate_of(input logic [3:0] idx);
    case (idx)
      4'd0, 4'd1: rate_of = 12'd372;
      4'd2:       rate_of = 12'd558;
      4'd3:       rate_of = 12'd744;
      4'd4:       rate_of = 12'd1116;
      4'd5:       rate_of = 12'd1488;
      4'd6:       rate_of = 12'd1860;
      4'd9:       rate_of = 12'd512;
      4'd10:      rate_of = 12'd768;
      4'd11:      rate_of = 12'd1024;
      4'd12:      rate_of = 12'd1536;
      4'd13:      rate_of = 12'd2048;
      default:    rate_of = 12'd0;
    endcase
  endfunction

  // Baud rate adjustment factor from its index; zero marks a reserved code.
  function automatic logic [6:0] div_of(input logic [3:0] idx);
    case (idx)
      4'd1:    div_of = 7'd1;
      4'd2:    div_of = 7'd2;
      4'd3:    div_of = 7'd4;
      4'd4:    div_of = 7'd8;
      4'd5:    div_of = 7'd16;
      4'd6:    div_of = 7'd32;
      4'd7:    div_of = 7'd64;
      4'd8:    div_of = 7'd12;
      4'd9:    div_of = 7'd20;
      default: div_of = 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/pps_rate_lut.sv
module pps_rate_lut #(
  parameter int HALF_W = 8
) (
  input  logic [7:0]        param_byte,
  output logic              rate_ok,
  output logic [HALF_W-1:0] half_etu
);
  import pps_pkg::*;

  localparam int LIMIT = 1 << HALF_W;

  logic [11:0] f_val;
  logic [11:0] den;
  logic [11:0] quo;
  logic [11:0] rem;

  always_comb begin
    f_val    = rate_of(param_byte[7:4]);
    den      = {4'b0, div_of(param_byte[3:0]), 1'b0};
    quo      = '0;
    rem      = '1;
    rate_ok  = 1'b0;
    half_etu = '0;
    if (f_val != '0 && den != '0) begin
      quo = f_val / den;
      rem = f_val % den;
      if (rem == '0 && quo != '0 && 32'(quo) < LIMIT) begin
        rate_ok  = 1'b1;
        half_etu = HALF_W'(quo);
      end
    end
  end

endmodule

// File: rtl/pps_seq.sv
module pps_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sess_start,
  input  logic       chr_valid,
  input  logic [7:0] chr_data,
  input  logic       rate_ok,
  output logic [7:0] param_q,
  output logic       fire
);
  import pps_pkg::*;

  trk_state_e st_q, st_n;
  logic [3:0] cnt_q, cnt_n;     // bytes left in the current group
  logic       tdp_q, tdp_n;     // current group ends with an indicator byte
  logic [3:0] hist_q, hist_n;   // historical bytes still to come
  logic       tck_q, tck_n;     // answer check byte expected
  logic [2:0] ropt_q, ropt_n;   // optional bytes announced by the request
  logic       echo_q, echo_n;   // response carries the first parameter byte
  logic [7:0] param_n;
  logic       adv;

  assign adv = sess_start | chr_valid;

  always_comb begin
    logic [3:0] y;
    logic       tck_v;
    logic [3:0] c;
    st_n    = st_q;
    cnt_n   = cnt_q;
    tdp_n   = tdp_q;
    hist_n  = hist_q;
    tck_n   = tck_q;
    ropt_n  = ropt_q;
    echo_n  = echo_q;
    param_n = param_q;
    fire    = 1'b0;
    y       = chr_data[7:4];
    tck_v   = tck_q;
    c       = '0;
    if (sess_start) begin
      st_n   = ST_TS;
      cnt_n  = '0;
      tdp_n  = 1'b0;
      hist_n = '0;
      tck_n  = 1'b0;
      ropt_n = '0;
      echo_n = 1'b0;
    end else if (chr_valid) begin
      case (st_q)
        ST_TS: st_n = (chr_data == 8'h3B) ? ST_T0 : ST_OFF;
        ST_T0: begin
          hist_n = chr_data[3:0];
          cnt_n  = 4'($countones(y));
          tdp_n  = y[3];
          if (y != '0)                 st_n = ST_IFC;
          else if (chr_data[3:0] != 0) st_n = ST_HIST;
          else                         st_n = ST_RQ_SS;
        end
        ST_IFC: begin
          cnt_n = cnt_q - 4'd1;
          if (cnt_q == 4'd1) begin
            if (tdp_q && chr_data[3:0] != '0) tck_v = 1'b1;
            tck_n = tck_v;
            if (tdp_q && y != '0) begin
              cnt_n = 4'($countones(y));
              tdp_n = y[3];
            end else if (hist_q != '0) st_n = ST_HIST;
            else if (tck_v)            st_n = ST_TCK;
            else                       st_n = ST_RQ_SS;
          end
        end
        ST_HIST: begin
          hist_n = hist_q - 4'd1;
          if (hist_q == 4'd1) st_n = tck_q ? ST_TCK : ST_RQ_SS;
        end
        ST_TCK:   st_n = ST_RQ_SS;
        ST_RQ_SS: st_n = (chr_data == 8'hFF) ? ST_RQ_P0 : ST_OFF;
        ST_RQ_P0: begin
          ropt_n = chr_data[6:4];
          c      = 4'($countones(chr_data[6:4]));
          cnt_n  = c;
          st_n   = (c != '0) ? ST_RQ_OPT : ST_RQ_CK;
        end
        ST_RQ_OPT: begin
          cnt_n = cnt_q - 4'd1;
          if (cnt_q == 4'd1) st_n = ST_RQ_CK;
        end
        ST_RQ_CK: st_n = ST_RS_SS;
        ST_RS_SS: st_n = (chr_data == 8'hFF) ? ST_RS_P0 : ST_OFF;
        ST_RS_P0: begin
          c      = 4'($countones(chr_data[6:5]));
          cnt_n  = c;
          echo_n = chr_data[4];
          if ((chr_data[6:4] & ~ropt_q) != '0) st_n = ST_OFF;
          else if (chr_data[4])                st_n = ST_RS_P1;
          else if (c != '0)                    st_n = ST_RS_OPT;
          else                                 st_n = ST_RS_CK;
        end
        ST_RS_P1: begin
          param_n = chr_data;
          st_n    = (cnt_q != '0) ? ST_RS_OPT : ST_RS_CK;
        end
        ST_RS_OPT: begin
          cnt_n = cnt_q - 4'd1;
          if (cnt_q == 4'd1) st_n = ST_RS_CK;
        end
        ST_RS_CK: begin
          fire = echo_q & rate_ok;
          st_n = ST_OFF;
        end
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      cnt_q   <= '0;
      tdp_q   <= 1'b0;
      hist_q  <= '0;
      tck_q   <= 1'b0;
      ropt_q  <= '0;
      echo_q  <= 1'b0;
      param_q <= '0;
    end else if (adv) begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      tdp_q   <= tdp_n;
      hist_q  <= hist_n;
      tck_q   <= tck_n;
      ropt_q  <= ropt_n;
      echo_q  <= echo_n;
      param_q <= param_n;
    end
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sess_start |=> st_q == ST_TS);
  assert_bad_ts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TS && chr_valid && !sess_start && chr_data != 8'h3B) |=> st_q == ST_OFF);
  assert_bad_ppss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RQ_SS && chr_valid && !sess_start && chr_data != 8'hFF) |=> st_q == ST_OFF);
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && !sess_start) |=> st_q == ST_OFF);

endmodule

// File: rtl/pps_tracker.sv
module pps_tracker #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_start,
  input  logic              chr_valid,
  input  logic [7:0]        chr_data,
  output logic              etu_load,
  output logic [HALF_W-1:0] etu_value,
  output logic              pps_act
);

  logic [7:0] param_q;
  logic       rate_ok;
  logic       fire;

  pps_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sess_start (sess_start),
    .chr_valid  (chr_valid),
    .chr_data   (chr_data),
    .rate_ok    (rate_ok),
    .param_q    (param_q),
    .fire       (fire)
  );

  pps_rate_lut #(.HALF_W(HALF_W)) u_lut (
    .param_byte (param_q),
    .rate_ok    (rate_ok),
    .half_etu   (etu_value)
  );

  assign etu_load = fire;
  assign pps_act  = fire;

  assert_load_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    etu_load |-> (chr_valid && !sess_start));
  assert_load_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    etu_load |-> etu_value != '0);

endmodule

// File: tb/tb_pps_tracker.sv
`timescale 1ns/1ps
module tb_pps_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sess_start = 1'b0;
  logic       chr_valid = 1'b0;
  logic [7:0] chr_data = '0;
  logic       etu_load;
  logic [7:0] etu_value;
  logic       pps_act;

  int checks = 0;
  int errors = 0;
  int nload = 0;
  int act_bad = 0;
  logic [7:0] lastv = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pps_tracker dut (
    .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .chr_valid(chr_valid),
    .chr_data(chr_data), .etu_load(etu_load), .etu_value(etu_value), .pps_act(pps_act)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    chr_valid = 1'b1;
    chr_data  = b;
    #1;
    if (etu_load) begin
      nload++;
      lastv = etu_value;
    end
    if (pps_act !== etu_load) act_bad++;
    @(negedge clk);
    chr_valid = 1'b0;
  endtask

  task automatic start();
    @(negedge clk);
    sess_start = 1'b1;
    @(negedge clk);
    sess_start = 1'b0;
    nload = 0;
  endtask

  task automatic expect_load(input int n, input int v, input string req);
    check(nload == n, req, nload, n);
    if (n != 0) check(lastv == v, req, lastv, v);
  endtask

  // request then response carrying one parameter byte
  task automatic pps_simple(input logic [7:0] p1);
    send(8'hFF); send(8'h10); send(p1); send(8'h00);
    send(8'hFF); send(8'h10); send(p1); send(8'h00);
  endtask

  task automatic t_reset_R1();
    check(etu_load == 1'b0 && pps_act == 1'b0, "R1 reset outputs", etu_load, 0);
    nload = 0;
    send(8'h3B); send(8'h00); pps_simple(8'h94);
    expect_load(0, 0, "R1 no session");
  endtask

  task automatic t_basic_R8();
    start();
    send(8'h3B); send(8'h00);
    send(8'hFF); send(8'h10); send(8'h94); send(8'h00);
    send(8'hFF); send(8'h10); send(8'h94);
    check(nload == 0, "R8 no early load", nload, 0);
    send(8'h00);
    expect_load(1, 32, "R8 F512 D8");
  endtask

  task automatic t_atr_tck_R4();
    start();
    send(8'h3B); send(8'hD2); send(8'h11); send(8'h00); send(8'h81);
    send(8'h31); send(8'h22); send(8'h33); send(8'h44); send(8'h55); send(8'h66);
    pps_simple(8'h12);
    expect_load(1, 93, "R4 chained groups with TCK");
  endtask

  task automatic t_atr_notck_R4();
    start();
    send(8'h3B); send(8'h80); send(8'h00);
    pps_simple(8'h96);
    expect_load(1, 8, "R4 protocol zero no TCK");
  endtask

  task automatic t_bad_ts_R3();
    start();
    send(8'h3F); send(8'h00); pps_simple(8'h94);
    expect_load(0, 0, "R3 wrong initial byte");
  endtask

  task automatic t_bad_ppss_R5();
    start();
    send(8'h3B); send(8'h00); send(8'hA0); pps_simple(8'h94);
    expect_load(0, 0, "R5 non-FF after answer");
  endtask

  task automatic t_opt_R6();
    start();
    send(8'h3B); send(8'h00);
    send(8'hFF); send(8'h70); send(8'h95); send(8'h01); send(8'h02); send(8'h00);
    send(8'hFF); send(8'h30); send(8'h95); send(8'h01); send(8'h00);
    expect_load(1, 16, "R6 three optional request bytes");
  endtask

  task automatic t_rsp_bad_R7();
    start();
    send(8'h3B); send(8'h00);
    send(8'hFF); send(8'h10); send(8'h94); send(8'h00);
    send(8'hFF); send(8'h30); send(8'h94); send(8'h00); send(8'h00);
    expect_load(0, 0, "R7 response bit not requested");
    start();
    send(8'h3B); send(8'h00);
    send(8'hFF); send(8'h10); send(8'h94); send(8'h00);
    send(8'h00); send(8'h10); send(8'h94); send(8'h00);
    expect_load(0, 0, "R7 response start not FF");
  endtask

  task automatic t_bad_rate_R9();
    start(); send(8'h3B); send(8'h00); pps_simple(8'hD1);
    expect_load(0, 0, "R9 too large");
    start(); send(8'h3B); send(8'h00); pps_simple(8'h14);
    expect_load(0, 0, "R9 non-integer");
    start(); send(8'h3B); send(8'h00); pps_simple(8'h71);
    expect_load(0, 0, "R9 reserved rate");
  endtask

  task automatic t_once_R10();
    start();
    send(8'h3B); send(8'h00); pps_simple(8'h94); pps_simple(8'h94);
    expect_load(1, 32, "R10 single load per session");
    start();
    send(8'h3B); send(8'h00); pps_simple(8'h93);
    expect_load(1, 64, "R10 new session works");
  endtask

  task automatic t_noecho_R11();
    start();
    send(8'h3B); send(8'h00);
    send(8'hFF); send(8'h10); send(8'h94); send(8'h00);
    send(8'hFF); send(8'h00); send(8'h00);
    expect_load(0, 0, "R11 no echo");
  endtask

  task automatic t_restart_R2();
    start();
    send(8'h3B); send(8'h00);
    send(8'hFF); send(8'h10); send(8'h94); send(8'h00);
    send(8'hFF); send(8'h10); send(8'h94);
    @(negedge clk);
    sess_start = 1'b1; chr_valid = 1'b1; chr_data = 8'h00;
    #1;
    check(etu_load == 1'b0, "R2 start wins over strobe", etu_load, 0);
    @(negedge clk);
    sess_start = 1'b0; chr_valid = 1'b0;
    nload = 0;
    send(8'h3B); send(8'h00); pps_simple(8'h94);
    expect_load(1, 32, "R2 restart mid exchange");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R1();
    t_basic_R8();
    t_atr_tck_R4();
    t_atr_notck_R4();
    t_bad_ts_R3();
    t_bad_ppss_R5();
    t_opt_R6();
    t_rsp_bad_R7();
    t_bad_rate_R9();
    t_once_R10();
    t_noecho_R11();
    t_restart_R2();
    check(act_bad == 0, "R8 action flag tracks load", act_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule